// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block sits between a processor port and a slower main-memory port. Addresses are word addresses and each word is 8 bits wide. The cache holds 16 lines of 8 words, which is 128 bytes of data. Each line also keeps a stored tag, a valid bit and a dirty bit. A 14-bit address is split into three fields: a word offset, a line index and a tag. A request that hits is served in the same cycle it is presented. A write hit changes only the cached copy and marks the line as modified.

On a miss the controller loads the whole line from memory, one word per memory handshake. If the line being replaced has been modified, its eight words are first copied back to memory. The processor keeps its request asserted until it sees the completion pulse. While a miss is being serviced, requests are held off. When the refill ends, the same request is looked up again and completes as a hit. A write miss therefore first brings the line in and then applies the store.

Top module: `dmc_wb_cache`

## Requirements
- R1: Address field positions are fixed: word offset in bits [2:0], line index in bits [6:3], tag in bits [13:7]. Every memory address the block issues has the same layout.
- R2: After reset every line is invalid. The first access to any address after reset misses and triggers a refill, even if that line was valid before reset. `cpu_done` and `mem_req` are 0 while reset is asserted.
- R3: A request hits only when its line is valid and the stored tag equals the address tag. A hit raises `cpu_done` in the same cycle as the request. On a read hit, `cpu_rdata` carries the word. A hit causes no memory traffic.
- R4: A write hit updates only the cached word and marks the line dirty. No memory transaction follows from it.
- R5: A read miss refills all 8 words of the line in ascending offset order, starting at offset 0, at memory address {address tag, index, offset}. The request then completes with the fetched word.
- R6: When the line being replaced is dirty, its 8 words are written to memory at {stored tag, index, offset 0..7} before any refill read starts. Memory then holds the values last written into the cache.
- R7: A line brought in by a read miss is clean. Replacing it later issues refill reads only, with no write-back.
- R8: A write miss allocates the line first: a write-back if the line is dirty, then a full refill. It then applies the store and leaves the line dirty, so the next replacement of that line writes it back.
- R9: `cpu_done` is never high while `mem_req` is high.
- R10: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack` is seen. Each `mem_ack` completes exactly one word.
- R11: Every read returns the value most recently written to that address, or the memory's value if the address was never written, across any mix of hits, misses and replacements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request; held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 14 | Word address {tag, index, offset} |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Load data, valid with `cpu_done` |
| cpu_done | output | 1 | Completion of the current request |
| mem_req | output | 1 | Memory word transaction pending |
| mem_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 8 | Write-back data |
| mem_rdata | input | 8 | Refill data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes one word |

## Verification
The embedded assertions check the following on every cycle:
- the memory handshake stays stable until it is acknowledged;
- completion is excluded while memory is busy;
- a refill always starts at offset 0;
- a refill can follow a write-back only after all 8 words have been acknowledged;
- reset leaves every line invalid.

Other behaviour can only be shown by the bench scenarios. These cover the exact count and order of write-back and refill words, the stored tag used for write-back addresses, and the clean-versus-dirty choice on replacement. They also cover the write-miss allocation path and the data values returned across replacements.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_FILL  = 2'd2
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int INDEX_W = 4,
   parameter int TAG_W   = 7,
   parameter int LINES   = 1 << INDEX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic               lk_hit,
   output logic               lk_valid,
   output logic               lk_dirty,
   output logic [TAG_W-1:0]   lk_tag_q,
   input  logic               fill_en,
   input  logic [TAG_W-1:0]   fill_tag,
   input  logic               mark_en
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   // tags carry no reset: they are meaningless until the valid bit is set
   always_ff @(posedge clk) begin
      if (fill_en) tag_q[lk_idx] <= fill_tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (fill_en) begin
            valid_q[lk_idx] <= 1'b1;
            dirty_q[lk_idx] <= 1'b0;
         end else if (mark_en) begin
            dirty_q[lk_idx] <= 1'b1;
         end
      end
   end

   assign lk_valid = valid_q[lk_idx];
   assign lk_dirty = dirty_q[lk_idx];
   assign lk_tag_q = tag_q[lk_idx];
   assign lk_hit   = lk_valid && (lk_tag_q == lk_tag);

   p_reset_clears_r2: assert property (@(posedge clk) !rst_n |=> (valid_q == '0 && dirty_q == '0))
      else $error("R2: lines not invalid after reset");
endmodule

// File: rtl/dmc_line_ram.sv
module dmc_line_ram #(
   parameter int WORD_W     = 8,
   parameter int INDEX_W    = 4,
   parameter int OFFSET_W   = 3,
   parameter bit CLEAR_DATA = 1'b0,
   parameter int DEPTH      = 1 << (INDEX_W + OFFSET_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [INDEX_W-1:0]  w_idx,
   input  logic [OFFSET_W-1:0] w_off,
   input  logic [WORD_W-1:0]   w_data,
   input  logic [INDEX_W-1:0]  ra_idx,
   input  logic [OFFSET_W-1:0] ra_off,
   output logic [WORD_W-1:0]   ra_data,
   input  logic [INDEX_W-1:0]  rb_idx,
   input  logic [OFFSET_W-1:0] rb_off,
   output logic [WORD_W-1:0]   rb_data
);
   logic [WORD_W-1:0] words [DEPTH];

   generate
      if (CLEAR_DATA) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) words[i] <= '0;
            end else if (we) begin
               words[{w_idx, w_off}] <= w_data;
            end
         end
      end else begin : g_keep
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we) words[{w_idx, w_off}] <= w_data;
         end
      end
   endgenerate

   assign ra_data = words[{ra_idx, ra_off}];
   assign rb_data = words[{rb_idx, rb_off}];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int OFFSET_W = 3,
   parameter int INDEX_W  = 4,
   parameter int TAG_W    = 7,
   parameter int ADDR_W   = TAG_W + INDEX_W + OFFSET_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic [TAG_W-1:0]    cpu_tag,
   input  logic [INDEX_W-1:0]  cpu_idx,
   input  logic                lk_hit,
   input  logic                lk_valid,
   input  logic                lk_dirty,
   input  logic [TAG_W-1:0]    victim_tag,
   input  logic                mem_ack,
   output logic                idle,
   output logic [INDEX_W-1:0]  line_idx,
   output logic [OFFSET_W-1:0] word_cnt,
   output logic                fill_wr,
   output logic                fill_done,
   output logic [TAG_W-1:0]    fill_tag,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr
);
   localparam logic [OFFSET_W-1:0] LAST = '1;

   dmc_state_e          state;
   logic [TAG_W-1:0]    miss_tag;
   logic [INDEX_W-1:0]  miss_idx;
   logic [OFFSET_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         miss_tag <= '0;
         miss_idx <= '0;
      end else begin
         case (state)
            ST_IDLE: if (cpu_req && !lk_hit) begin
               miss_tag <= cpu_tag;
               miss_idx <= cpu_idx;
               cnt      <= '0;
               state    <= (lk_valid && lk_dirty) ? ST_EVICT : ST_FILL;
            end
            ST_EVICT: if (mem_ack) begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) state <= ST_FILL;
            end
            ST_FILL: if (mem_ack) begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle      = (state == ST_IDLE);
   assign line_idx  = idle ? cpu_idx : miss_idx;
   assign word_cnt  = cnt;
   assign fill_wr   = (state == ST_FILL) && mem_ack;
   assign fill_done = fill_wr && (cnt == LAST);
   assign fill_tag  = miss_tag;
   assign mem_req   = !idle;
   assign mem_we    = (state == ST_EVICT);
   assign mem_addr  = {(state == ST_EVICT) ? victim_tag : miss_tag, miss_idx, cnt};

   p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
      else $error("R10: memory request changed before ack");

   p_fill_from_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && $past(state) != ST_FILL) |-> (cnt == '0))
      else $error("R5: refill did not start at offset 0");

   p_evict_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && $past(state) == ST_EVICT) |-> ($past(cnt) == LAST && $past(mem_ack)))
      else $error("R6: refill began before write-back finished");
endmodule

// File: rtl/dmc_wb_cache.sv
module dmc_wb_cache #(
   parameter int WORD_W     = 8,
   parameter int OFFSET_W   = 3,
   parameter int INDEX_W    = 4,
   parameter int TAG_W      = 7,
   parameter int ADDR_W     = 14,
   parameter bit CLEAR_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int LINES = 1 << INDEX_W;

   generate
      if (ADDR_W != TAG_W + INDEX_W + OFFSET_W) begin : g_bad_split
         $error("address width must equal tag + index + offset widths");
      end
      if (WORD_W < 1 || OFFSET_W < 1 || INDEX_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("all field widths must be at least one bit");
      end
   endgenerate

   // R1: field split of the processor address
   logic [OFFSET_W-1:0] cpu_off;
   logic [INDEX_W-1:0]  cpu_idx;
   logic [TAG_W-1:0]    cpu_tag;
   assign cpu_off = cpu_addr[OFFSET_W-1:0];
   assign cpu_idx = cpu_addr[OFFSET_W +: INDEX_W];
   assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

   logic                idle, lk_hit, lk_valid, lk_dirty;
   logic [TAG_W-1:0]    victim_tag, fill_tag;
   logic [INDEX_W-1:0]  line_idx;
   logic [OFFSET_W-1:0] word_cnt;
   logic                fill_wr, fill_done, hit_wr;

   assign cpu_done = cpu_req && idle && lk_hit;
   assign hit_wr   = cpu_done && cpu_we;

   dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .LINES(LINES)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (line_idx),
      .lk_tag   (cpu_tag),
      .lk_hit   (lk_hit),
      .lk_valid (lk_valid),
      .lk_dirty (lk_dirty),
      .lk_tag_q (victim_tag),
      .fill_en  (fill_done),
      .fill_tag (fill_tag),
      .mark_en  (hit_wr)
   );

   dmc_ctrl #(.OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_tag    (cpu_tag),
      .cpu_idx    (cpu_idx),
      .lk_hit     (lk_hit),
      .lk_valid   (lk_valid),
      .lk_dirty   (lk_dirty),
      .victim_tag (victim_tag),
      .mem_ack    (mem_ack),
      .idle       (idle),
      .line_idx   (line_idx),
      .word_cnt   (word_cnt),
      .fill_wr    (fill_wr),
      .fill_done  (fill_done),
      .fill_tag   (fill_tag),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr)
   );

   dmc_line_ram #(.WORD_W(WORD_W), .INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W),
                  .CLEAR_DATA(CLEAR_DATA)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (hit_wr || fill_wr),
      .w_idx   (line_idx),
      .w_off   (fill_wr ? word_cnt : cpu_off),
      .w_data  (fill_wr ? mem_rdata : cpu_wdata),
      .ra_idx  (cpu_idx),
      .ra_off  (cpu_off),
      .ra_data (cpu_rdata),
      .rb_idx  (line_idx),
      .rb_off  (word_cnt),
      .rb_data (mem_wdata)
   );

   p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !mem_req)
      else $error("R9: completion while memory busy");

   p_hit_no_traffic_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !mem_req)
      else $error("R3: hit started memory traffic");
endmodule

// File: tb/dmc_wb_cache_bench.sv
module dmc_wb_cache_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [13:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        cpu_done, mem_req, mem_we;
   logic [13:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_ack = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dmc_wb_cache u_dmc_wb_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack)
   );

   int n_tests = 0, n_fail = 0;
   logic [7:0] memv [int];
   logic [7:0] gold [int];
   logic [7:0] exp_q [$];

   function automatic logic [7:0] init_val(int a);
      return 8'(a * 37 + 11);
   endfunction
   function automatic logic [7:0] mem_rd(int a);
      return memv.exists(a) ? memv[a] : init_val(a);
   endfunction
   function automatic logic [7:0] gold_rd(int a);
      return gold.exists(a) ? gold[a] : init_val(a);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: random latency, one ack per word
   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else begin
         if (mem_req && mem_we && mem_ack) memv[int'(mem_addr)] = mem_wdata;
         mem_ack <= mem_req && !mem_ack && ($urandom_range(0, 2) != 0);
         mem_rdata <= mem_rd(int'(mem_addr));
      end
   end

   // monitor: traffic bookkeeping and scoreboard
   int n_rd, n_wr, rd_base, wr_base, seq_err;
   always @(negedge clk) begin
      #3;
      if (rst_n && mem_req && mem_ack) begin
         if (mem_we) begin
            if (n_wr == 0) wr_base = int'(mem_addr);
            if (int'(mem_addr) != wr_base + n_wr || n_rd != 0) seq_err++;
            n_wr++;
         end else begin
            if (n_rd == 0) rd_base = int'(mem_addr);
            if (int'(mem_addr) != rd_base + n_rd) seq_err++;
            n_rd++;
         end
      end
      if (rst_n && cpu_done && !cpu_we) begin
         if (exp_q.size() == 0) check(1'b0, "R11 unexpected read completion", 1, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(cpu_rdata == e, "R11 read data", cpu_rdata, e);
         end
      end
   end

   int lat;
   task automatic access(input bit we, input int addr, input logic [7:0] d);
      @(negedge clk);
      n_rd = 0; n_wr = 0; seq_err = 0; rd_base = -1; wr_base = -1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = 14'(addr); cpu_wdata = d;
      if (we) gold[addr] = d;
      else exp_q.push_back(gold_rd(addr));
      lat = 0;
      forever begin
         #3;
         if (cpu_done) break;
         @(negedge clk);
         lat++;
      end
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic traffic(input string req, input int ewr, input int erd);
      check(n_wr == ewr, {req, " write-back count"}, n_wr, ewr);
      check(n_rd == erd, {req, " refill count"}, n_rd, erd);
      check(seq_err == 0, {req, " word order"}, seq_err, 0);
   endtask

   localparam int A = 14'h3AB;  // tag 7, index 5, offset 3
   localparam int B = 14'h4A9;  // tag 9, index 5, offset 1
   localparam int C = 14'h12E;  // tag 2, index 5, offset 6

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state at the ports
      check(cpu_done == 1'b0, "R2 done in reset", cpu_done, 0);
      check(mem_req == 1'b0, "R2 mem_req in reset", mem_req, 0);
      rst_n = 1'b1;

      // R5, R1, R2: cold read miss refills whole line from offset 0
      access(0, A, 0);
      traffic("R5", 0, 8);
      check(rd_base == 14'h3A8, "R1 refill base address", rd_base, 14'h3A8);
      check(lat > 0, "R2 first access misses", lat, 1);

      // R3: read hit in the same line
      access(0, A + 1, 0);
      check(lat == 0, "R3 hit latency", lat, 0);
      traffic("R3", 0, 0);

      // R4: write hit stays in cache
      access(1, A, 8'h5A);
      check(lat == 0, "R4 write hit latency", lat, 0);
      traffic("R4", 0, 0);
      check(mem_rd(A) == init_val(A), "R4 memory untouched", mem_rd(A), init_val(A));
      access(0, A, 0);

      // R6: dirty replacement writes back under the stored tag first
      access(0, B, 0);
      traffic("R6", 8, 8);
      check(wr_base == 14'h3A8, "R6 write-back base", wr_base, 14'h3A8);
      check(rd_base == 14'h4A8, "R6 refill base", rd_base, 14'h4A8);
      check(mem_rd(A) == 8'h5A, "R6 written-back value", mem_rd(A), 8'h5A);

      // R7: line from read miss is clean
      access(0, A, 0);
      traffic("R7", 0, 8);

      // R8: write miss allocates, stores, leaves line dirty
      access(1, C, 8'h33);
      traffic("R8", 0, 8);
      access(0, C, 0);
      check(lat == 0, "R8 store visible as hit", lat, 0);
      access(0, B, 0);
      traffic("R8", 8, 8);
      check(wr_base == 14'h128, "R8 write-back base", wr_base, 14'h128);
      check(mem_rd(C) == 8'h33, "R8 stored value in memory", mem_rd(C), 8'h33);

      // R2: reset forgets a valid line
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      access(0, B, 0);
      traffic("R2", 0, 8);

      // R11, R9, R10: random mix over a few conflicting tags
      for (int i = 0; i < 400; i++) begin
         int a;
         a = ($urandom_range(0, 3) << 7) | ($urandom_range(0, 3) << 3) | $urandom_range(0, 7);
         access($urandom_range(0, 1) == 1, a, 8'($urandom));
      end
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R11 all reads completed", exp_q.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule